// File: doc/BRIEF.md
# Byte-Lane Word Memory Target for a Load/Store Bus

This block is a word-organised memory that sits on the data side of a processor's load/store port. A requester raises an enable together with a 32-bit address, a read strobe, a write strobe, a 4-bit lane mask and 32-bit write data. The target answers with an acknowledge and 32-bit read data. A read always returns the whole aligned word. Any byte or halfword extraction based on the two low address bits is done by the requester. A write changes only the byte lanes that the lane mask selects.

The acknowledge can follow the enable in the same cycle, so one access takes one clock and a new access can start in the next cycle. The parameter `WAIT_STATES` stretches every access by a fixed number of cycles. Write data and the lane mask are committed on the clock edge that acknowledges them. Requests whose strobes contradict each other, and writes with a lane mask outside the legal set, are still acknowledged. They change nothing and set a sticky error flag. Addresses above the configured depth read as zero, are never written and raise no error.

Top module: `dbus_mem_target`

## Requirements
- R1: A read (enable=1, rd=1, wr=0) returns the full 32-bit word held at word index address[31:2]. Address bits 1:0 have no effect on the word returned.
- R2: A write (enable=1, rd=0, wr=1) with a legal lane mask updates only the selected lanes: mask bit 3 selects data bits 31:24, bit 2 selects 23:16, bit 1 selects 15:8 and bit 0 selects 7:0. Lanes that are not selected keep their old value.
- R3: The legal lane masks are 4'b1111, 4'b1100, 4'b0011, 4'b1000, 4'b0100, 4'b0010 and 4'b0001. A write with any other mask is acknowledged, changes no stored byte and sets the error flag.
- R4: A request with enable=1 and rd equal to wr (both 0 or both 1) is acknowledged, reads back zero, writes nothing and sets the error flag.
- R5: With WAIT_STATES=0, ack is high in every cycle that enable is high. With WAIT_STATES=N, ack rises in the (N+1)-th consecutive cycle of enable. Ack is never high while enable is low.
- R6: After an acknowledged access, a new access that keeps or raises enable in the very next cycle is timed from zero again, and it observes the effects of the previous write.
- R7: Addresses with address[31:2] at or above the depth in words read as zero, are not written (they do not alias onto lower words) and do not set the error flag.
- R8: After reset the error flag is 0 and every stored word reads as zero. Once set, the error flag stays at 1 until the next reset.
- R9: Read data is zero in every cycle that is not an acknowledged read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 1 | Request enable, held until acknowledged |
| req_addr | input | 32 | Byte address of the access |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_lanes | input | 4 | Byte lane mask for writes |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Access completes on the next rising edge |
| rsp_rdata | output | 32 | Read data, valid with ack on a read |
| proto_err | output | 1 | Sticky flag for illegal strobes or lane masks |

## Verification
Several properties are checked on every cycle. Ack never appears without enable. With wait states, ack comes only after an unacknowledged enable cycle. The error flag is sticky and rises only after an acknowledged bad request. A commit never carries an illegal lane mask or an out-of-range address. Non-zero read data appears only on an acknowledged read. The stored contents cannot be seen by a property, so only the bench's scenarios can show the following:
- lane merging;
- address bits 1:0 having no effect;
- out-of-range writes not aliasing onto lower words;
- illegal requests leaving memory untouched;
- the exact wait-state count across back-to-back accesses.

// File: rtl/dbus_mem_pkg.sv
package dbus_mem_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_BAD   = 2'd3
   } dbus_op_e;

   // Accepted lane masks: full word, either halfword, any single byte.
   function automatic logic lane_mask_ok(input logic [3:0] m);
      logic ok;
      case (m)
         4'b1111, 4'b1100, 4'b0011,
         4'b1000, 4'b0100, 4'b0010, 4'b0001: ok = 1'b1;
         default:                           ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/dbus_req_decode.sv
module dbus_req_decode
   import dbus_mem_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int LANES       = 4,
   parameter int DEPTH_WORDS = 64,
   localparam int IDX_W      = $clog2(DEPTH_WORDS),
   localparam int WA_W       = ADDR_W - 2
) (
   input  logic             req_en,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic             req_rd,
   input  logic             req_wr,
   input  logic [LANES-1:0] req_lanes,
   output dbus_op_e         op,
   output logic             in_range,
   output logic [IDX_W-1:0] word_idx
);

   localparam logic [WA_W-1:0] SPAN = WA_W'(DEPTH_WORDS);

   // Byte offset inside the word is the requester's concern.
   logic unused_byte_ofs;
   assign unused_byte_ofs = ^req_addr[1:0];

   always_comb begin
      op = OP_IDLE;
      if (req_en) begin
         if (req_rd && !req_wr)
            op = OP_READ;
         else if (!req_rd && req_wr)
            op = lane_mask_ok(req_lanes) ? OP_WRITE : OP_BAD;
         else
            op = OP_BAD;
      end
   end

   assign in_range = (req_addr[ADDR_W-1:2] < SPAN);
   assign word_idx = req_addr[2 +: IDX_W];

endmodule

// File: rtl/dbus_ack_timer.sv
module dbus_ack_timer #(
   parameter int WAIT_STATES = 0,
   localparam int CNT_W      = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_en,
   output logic ack
);

   generate
      if (WAIT_STATES == 0) begin : g_nowait
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign ack = req_en;
      end else begin : g_wait
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!req_en || ack)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign ack = req_en && (cnt == CNT_W'(WAIT_STATES));

         // R5: an ack is preceded by an enabled, unacknowledged cycle
         p_ack_after_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ack |-> $past(req_en && !ack));

         // R5: the wait counter never passes its limit
         p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CNT_W'(WAIT_STATES));
      end
   endgenerate

endmodule

// File: rtl/dbus_lane_mem.sv
module dbus_lane_mem #(
   parameter int DATA_W      = 32,
   parameter int DEPTH_WORDS = 64,
   localparam int LANES      = DATA_W / 8,
   localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LANES-1:0]  wr_lanes,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [7:0] cells [DEPTH_WORDS];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int w = 0; w < DEPTH_WORDS; w++)
                  cells[w] <= 8'h00;
            end else if (wr_en && wr_lanes[l]) begin
               cells[wr_idx] <= wr_data[l*8 +: 8];
            end
         end

         assign rd_word[l*8 +: 8] = cells[rd_idx];
      end

      if (LANES == 4) begin : g_chk4
         // R3: only word, halfword or single-byte masks reach the array
         p_commit_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> ($countones(wr_lanes) == 4 || $countones(wr_lanes) == 1 ||
                       wr_lanes == 4'b1100 || wr_lanes == 4'b0011));
      end
   endgenerate

endmodule

// File: rtl/dbus_mem_target.sv
module dbus_mem_target
   import dbus_mem_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int DEPTH_WORDS = 64,
   parameter int WAIT_STATES = 0,
   localparam int LANES      = DATA_W / 8,
   localparam int IDX_W      = $clog2(DEPTH_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_en,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_rd,
   input  logic              req_wr,
   input  logic [LANES-1:0]  req_lanes,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_ack,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              proto_err
);

   initial begin : elab_chk
      assert (DATA_W == 32) else $error("DATA_W must be 32");
      assert (ADDR_W > IDX_W + 2) else $error("ADDR_W too small for DEPTH_WORDS");
      assert (DEPTH_WORDS >= 2 && (DEPTH_WORDS & (DEPTH_WORDS - 1)) == 0)
         else $error("DEPTH_WORDS must be a power of two >= 2");
      assert (WAIT_STATES >= 0) else $error("WAIT_STATES must be >= 0");
   end

   dbus_op_e         op;
   logic             in_range;
   logic [IDX_W-1:0] word_idx;
   logic [DATA_W-1:0] stored_word;
   logic             commit;

   dbus_req_decode #(
      .ADDR_W      (ADDR_W),
      .LANES       (LANES),
      .DEPTH_WORDS (DEPTH_WORDS)
   ) u_decode (
      .req_en    (req_en),
      .req_addr  (req_addr),
      .req_rd    (req_rd),
      .req_wr    (req_wr),
      .req_lanes (req_lanes),
      .op        (op),
      .in_range  (in_range),
      .word_idx  (word_idx)
   );

   dbus_ack_timer #(
      .WAIT_STATES (WAIT_STATES)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_en (req_en),
      .ack    (rsp_ack)
   );

   assign commit = rsp_ack && (op == OP_WRITE) && in_range;

   dbus_lane_mem #(
      .DATA_W      (DATA_W),
      .DEPTH_WORDS (DEPTH_WORDS)
   ) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (commit),
      .wr_idx   (word_idx),
      .wr_lanes (req_lanes),
      .wr_data  (req_wdata),
      .rd_idx   (word_idx),
      .rd_word  (stored_word)
   );

   assign rsp_rdata = (rsp_ack && op == OP_READ && in_range) ? stored_word : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         proto_err <= 1'b0;
      else if (rsp_ack && op == OP_BAD)
         proto_err <= 1'b1;
   end

   // R5: no acknowledge without a request
   p_ack_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |-> req_en);

   // R8: error flag holds once set
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   // R3, R4: error rises only after an acknowledged contradictory or badly masked request
   p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(proto_err) |-> $past(rsp_ack && (req_rd == req_wr ||
                                 (req_wr && !lane_mask_ok(req_lanes)))));

   // R7: nothing is committed beyond the configured depth
   p_oor_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (req_addr[ADDR_W-1:2] < (ADDR_W-2)'(DEPTH_WORDS)));

   // R9: non-zero read data only on an acknowledged read
   p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_rdata != '0) |-> (rsp_ack && req_rd && !req_wr));

endmodule

// File: tb/tb_dbus_mem_target.sv
module tb_dbus_mem_target;

   localparam int DEPTH = 16;
   localparam int WS    = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   always #10 clk = ~clk;

   // zero-wait instance
   logic        en = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [31:0] addr = '0, wdata = '0;
   logic [3:0]  lanes = '0;
   logic        ack, err;
   logic [31:0] rdata;

   // wait-state instance
   logic        w_en = 1'b0, w_rd = 1'b0, w_wr = 1'b0;
   logic [31:0] w_addr = '0, w_wdata = '0;
   logic [3:0]  w_lanes = '0;
   logic        w_ack, w_err;
   logic [31:0] w_rdata;

   dbus_mem_target #(.DEPTH_WORDS(DEPTH), .WAIT_STATES(0)) dut (
      .clk(clk), .rst_n(rst_n), .req_en(en), .req_addr(addr), .req_rd(rd),
      .req_wr(wr), .req_lanes(lanes), .req_wdata(wdata),
      .rsp_ack(ack), .rsp_rdata(rdata), .proto_err(err));

   dbus_mem_target #(.DEPTH_WORDS(DEPTH), .WAIT_STATES(WS)) dut_ws (
      .clk(clk), .rst_n(rst_n), .req_en(w_en), .req_addr(w_addr), .req_rd(w_rd),
      .req_wr(w_wr), .req_lanes(w_lanes), .req_wdata(w_wdata),
      .rsp_ack(w_ack), .rsp_rdata(w_rdata), .proto_err(w_err));

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] model [DEPTH];
   bit          err_model = 1'b0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic bit legal_mask(input logic [3:0] m);
      return (m == 4'hF || m == 4'hC || m == 4'h3 || m == 4'h8 ||
              m == 4'h4 || m == 4'h2 || m == 4'h1);
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                         input logic [3:0] m);
      logic [31:0] r = old;
      for (int i = 0; i < 4; i++)
         if (m[i]) r[i*8 +: 8] = d[i*8 +: 8];
      return r;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      en = 1'b0; w_en = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      err_model = 1'b0;
   endtask

   // One access on the zero-wait instance, checked in its single cycle.
   task automatic xfer(input bit r, input bit w, input logic [3:0] m,
                       input logic [31:0] a, input logic [31:0] d, input string rq);
      logic [31:0] exp;
      bit inr;
      @(negedge clk);
      en = 1'b1; rd = r; wr = w; lanes = m; addr = a; wdata = d;
      #1;
      inr = (a[31:2] < DEPTH);
      exp = (r && !w && inr) ? model[a[5:2]] : 32'h0;
      chk(ack === 1'b1, {rq, " R5 ack same cycle"}, {31'b0, ack}, 32'h1);
      chk(rdata === exp, {rq, " rdata"}, rdata, exp);
      chk(err === err_model, {rq, " R8 error flag"}, {31'b0, err}, {31'b0, err_model});
      if (!r && w && legal_mask(m) && inr)
         model[a[5:2]] = merge(model[a[5:2]], d, m);
      if (r == w || (w && !legal_mask(m)))
         err_model = 1'b1;
   endtask

   task automatic idle(input string rq);
      @(negedge clk);
      en = 1'b0; rd = 1'b0; wr = 1'b0;
      #1;
      chk(ack === 1'b0, {rq, " R5 no ack when idle"}, {31'b0, ack}, 32'h0);
      chk(rdata === 32'h0, {rq, " R9 idle rdata"}, rdata, 32'h0);
      chk(err === err_model, {rq, " R8 error flag"}, {31'b0, err}, {31'b0, err_model});
   endtask

   task automatic ws_xfer(input bit r, input bit w, input logic [3:0] m,
                          input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] q, output int waits);
      @(negedge clk);
      w_en = 1'b1; w_rd = r; w_wr = w; w_lanes = m; w_addr = a; w_wdata = d;
      waits = 0;
      q = '0;
      for (int k = 0; k < 20; k++) begin
         #1;
         if (w_ack === 1'b1) begin
            q = w_rdata;
            break;
         end
         waits++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      logic [31:0] q;
      int waits;
      void'($urandom(32'd20250611));
      do_reset();

      // R8: reset state
      idle("reset R8");
      xfer(1, 0, 4'hF, 32'h0, 0, "R8 memory zero after reset");
      xfer(1, 0, 4'hF, 32'h3C, 0, "R8 top word zero after reset");

      // R1, R6: full word write then back-to-back reads, low bits ignored
      xfer(0, 1, 4'hF, 32'h4, 32'h11223344, "R1 word write");
      xfer(1, 0, 4'h0, 32'h4, 0, "R6 back-to-back read");
      xfer(1, 0, 4'h0, 32'h7, 0, "R1 low address bits ignored");

      // R2: lane merges
      xfer(0, 1, 4'h8, 32'h4, 32'hAAFFFFFF, "R2 lane 3");
      xfer(0, 1, 4'h1, 32'h5, 32'hFFFFFFEE, "R2 lane 0");
      xfer(1, 0, 4'h0, 32'h4, 0, "R2 merged read");
      xfer(0, 1, 4'hC, 32'h4, 32'h5566DEAD, "R2 upper half");
      xfer(0, 1, 4'h3, 32'h4, 32'hBEEF7788, "R2 lower half");
      xfer(0, 1, 4'h4, 32'h8, 32'h00990000, "R2 lane 2");
      xfer(0, 1, 4'h2, 32'h8, 32'h00007700, "R2 lane 1");
      xfer(1, 0, 4'h0, 32'h4, 0, "R2 halves read");
      xfer(1, 0, 4'h0, 32'h8, 0, "R2 middle lanes read");

      // R7: out of range, no alias, no error
      xfer(0, 1, 4'hF, DEPTH * 4, 32'hCAFEF00D, "R7 oor write");
      xfer(0, 1, 4'hF, DEPTH * 4 + 8, 32'h12345678, "R7 oor write alias 2");
      xfer(1, 0, 4'h0, DEPTH * 4, 0, "R7 oor read zero");
      xfer(1, 0, 4'h0, 32'h0, 0, "R7 no alias word 0");
      xfer(1, 0, 4'h0, 32'h8, 0, "R7 no alias word 2");
      idle("R7 no error after oor");

      // R3: illegal lane masks
      xfer(0, 1, 4'h5, 32'h4, 32'h0BADBAD0, "R3 illegal mask 0101");
      xfer(1, 0, 4'h0, 32'h4, 0, "R3 unchanged after 0101");
      xfer(0, 1, 4'hE, 32'h8, 32'h0BADBAD0, "R3 illegal mask 1110");
      xfer(0, 1, 4'h0, 32'h8, 32'h0BADBAD0, "R3 illegal mask 0000");
      xfer(1, 0, 4'h0, 32'h8, 0, "R3 unchanged after 1110/0000");
      idle("R3 error latched");

      // R8 reset clears; R4 contradictory strobes
      do_reset();
      idle("R8 error cleared by reset");
      xfer(1, 1, 4'hF, 32'h4, 32'hFFFFFFFF, "R4 rd and wr both high");
      xfer(1, 0, 4'h0, 32'h4, 0, "R4 nothing written");
      idle("R4 error set");
      do_reset();
      xfer(0, 0, 4'hF, 32'h8, 32'hFFFFFFFF, "R4 rd and wr both low");
      xfer(1, 0, 4'h0, 32'h8, 0, "R4 nothing written 2");
      idle("R4 error set 2");

      // R5, R6: wait-state instance
      do_reset();
      ws_xfer(0, 1, 4'hF, 32'h20, 32'hA5A55A5A, q, waits);
      chk(waits == WS, "R5 write wait count", waits, WS);
      ws_xfer(1, 0, 4'h0, 32'h20, 0, q, waits);
      chk(waits == WS, "R6 back-to-back wait count", waits, WS);
      chk(q === 32'hA5A55A5A, "R6 back-to-back read data", q, 32'hA5A55A5A);
      ws_xfer(0, 1, 4'h1, 32'h20, 32'h000000FF, q, waits);
      ws_xfer(1, 0, 4'h0, 32'h21, 0, q, waits);
      chk(q === 32'hA5A55AFF, "R2 lane write with waits", q, 32'hA5A55AFF);
      chk(waits == WS, "R5 read wait count", waits, WS);
      @(negedge clk);
      w_en = 1'b0;
      #1;
      chk(w_ack === 1'b0, "R5 ws no ack when idle", {31'b0, w_ack}, 32'h0);
      chk(w_err === 1'b0, "R8 ws no error", {31'b0, w_err}, 32'h0);

      // Random mix on the zero-wait instance
      for (int i = 0; i < 600; i++) begin
         int k;
         bit r, w;
         logic [31:0] a;
         k = $urandom % 8;
         if (k < 4) begin r = 1; w = 0; end
         else if (k < 7) begin r = 0; w = 1; end
         else begin r = bit'($urandom % 2); w = r; end
         a = $urandom_range(0, DEPTH * 4 + 15);
         xfer(r, w, 4'($urandom), a, $urandom, "R1/R2/R3 random");
         if ($urandom % 10 == 0) idle("R9 random idle");
      end
      idle("random end");

      summary();
      $finish;
   end

endmodule